// File: doc/BRIEF.md
# Byte-Port Command and Address Sequencer

This block sits at the front of a streamed mass memory that has no address bus. Commands, address bytes and data all come in on one byte-wide port with a single write strobe. A command flag beside the strobe marks a byte as a command. Bytes without the flag are data or command parameters. Commands are decoded only while the block is at rest.

An address-setup command makes the block take the next six unflagged bytes as two 24-bit word addresses. The start address comes first, then the end address, and each is sent most significant byte first. A write or read command then starts a transfer. The block walks a current address from the start address upwards in steps of one 8-word burst. It hands each burst to a memory controller through a request/done handshake. It returns to rest once the burst that covers the end address has completed. Refresh requests from a refresh timer are granted only while no burst is outstanding.

The transfer is set up once and then runs by itself. The memory side therefore never needs an address per word.

Top module: `stream_cmd_sequencer`

## Requirements
- R1: After reset, `status` is 0 (idle), `burst_req` is low and `burst_addr` is 0.
- R2: A flagged byte is decoded only when `status` is 0 (idle) or 4 (error). A flagged byte that arrives while loading or during a transfer leaves `status` and the transfer unchanged.
- R3: In idle, unflagged bytes are ignored. Flagged codes other than 0x01, 0x02 and 0x03, including 0x00 (no operation), are also ignored. In every such case `status` stays 0 and the loaded addresses are unchanged.
- R4: Code 0x01 (address setup) sets `status` to 1 (loading). The next six unflagged strobed bytes are taken as the start address, then the end address, each most significant byte first. Flagged bytes during loading are not counted. `status` stays 1 until the sixth byte.
- R5: If the loaded end address is below the start address, `status` becomes 4 (error). Write and read commands then leave `status` at 4 and issue no burst. An address-setup command is still accepted.
- R6: Code 0x02 (write) sets `status` to 2 and code 0x03 (read) sets `status` to 3, provided end ≥ start. The first burst has `burst_addr` equal to the start address. `burst_write` is 1 for a write and 0 for a read.
- R7: `burst_req` and `burst_addr` hold steady until `burst_done` is seen. The next burst's address is 8 higher.
- R8: `burst_addr` never exceeds the end address during a transfer. The transfer issues floor((end−start)/8)+1 bursts. `status` returns to 0 and `burst_req` is low after the last burst completes.
- R9: `refresh_ack` is high only while `refresh_req` is high and no burst is outstanding. No new burst starts while `refresh_req` is high. A request raised mid-burst is granted only after `burst_done`.
- R10: A `burst_done` while no burst is outstanding is ignored: `burst_addr` and `status` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_stb | input | 1 | Byte write strobe, one cycle per byte |
| cmd_flag | input | 1 | Marks the strobed byte as a command |
| byte_in | input | BYTE_W | Command, parameter or data byte |
| refresh_req | input | 1 | Refresh request from the refresh timer, held until granted |
| burst_done | input | 1 | One-cycle pulse from the memory controller ending a burst |
| burst_req | output | 1 | A burst at `burst_addr` is outstanding |
| burst_write | output | 1 | 1 for write transfer, 0 for read |
| refresh_ack | output | 1 | Refresh granted this cycle |
| burst_addr | output | ADDR_W | Current burst base word address |
| status | output | 3 | 0 idle, 1 loading, 2 writing, 3 reading, 4 error |

## Verification
The assertions assume the memory controller pulses `burst_done` for one cycle to end a burst it was asked for. They also assume the refresh timer holds `refresh_req` until it sees a grant, so a burst never starts during a held request. The stimulus keeps to this. Each strobe lasts one cycle. `burst_done` comes only after `burst_req` has been seen, except where a stray pulse is sent on purpose while nothing is outstanding. `refresh_req` is held across the grant and dropped only afterwards. Address pairs are chosen so that the current address never wraps past the top of the 24-bit space.

// File: rtl/seq_pkg.sv
package seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_LOAD  = 3'd1,
      ST_WRITE = 3'd2,
      ST_READ  = 3'd3,
      ST_ERROR = 3'd4
   } seq_state_e;

   typedef enum logic [1:0] {
      OP_NONE,
      OP_SETUP,
      OP_WRITE,
      OP_READ
   } seq_op_e;

   localparam int CODE_SETUP = 1;
   localparam int CODE_WRITE = 2;
   localparam int CODE_READ  = 3;
endpackage

// File: rtl/seq_cmd_decode.sv
module seq_cmd_decode
   import seq_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic [BYTE_W-1:0] code,
   output seq_op_e           op
);
   localparam logic [BYTE_W-1:0] K_SETUP = BYTE_W'(CODE_SETUP);
   localparam logic [BYTE_W-1:0] K_WRITE = BYTE_W'(CODE_WRITE);
   localparam logic [BYTE_W-1:0] K_READ  = BYTE_W'(CODE_READ);

   generate
      if (BYTE_W < 2) begin : g_bad_width
         $error("seq_cmd_decode: BYTE_W must be at least 2");
      end
   endgenerate

   // R3: any code outside the three known values decodes to no operation
   always_comb begin
      if (code == K_SETUP)      op = OP_SETUP;
      else if (code == K_WRITE) op = OP_WRITE;
      else if (code == K_READ)  op = OP_READ;
      else                      op = OP_NONE;
   end
endmodule

// File: rtl/seq_addr_loader.sv
module seq_addr_loader #(
   parameter int ADDR_W    = 24,
   parameter int BYTE_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic              take,
   input  logic [BYTE_W-1:0] din,
   output logic [ADDR_W-1:0] start_addr,
   output logic [ADDR_W-1:0] end_addr,
   output logic              last_byte,
   output logic              order_bad
);
   localparam int NB    = ADDR_W / BYTE_W;
   localparam int TOTAL = 2 * NB;
   localparam int CNT_W = $clog2(TOTAL + 1);
   localparam int SH_W  = 2 * ADDR_W;

   logic [SH_W-1:0]   sh_q, sh_d;
   logic [CNT_W-1:0]  left_q;
   logic              accept;
   logic [ADDR_W-1:0] nxt_start, nxt_end;

   generate
      if (ADDR_W % BYTE_W != 0) begin : g_bad_ratio
         $error("seq_addr_loader: ADDR_W must be a multiple of BYTE_W");
      end
      if (MSB_FIRST) begin : g_msb
         assign sh_d       = {sh_q[SH_W-BYTE_W-1:0], din};
         assign start_addr = sh_q[SH_W-1:ADDR_W];
         assign end_addr   = sh_q[ADDR_W-1:0];
         assign nxt_start  = sh_d[SH_W-1:ADDR_W];
         assign nxt_end    = sh_d[ADDR_W-1:0];
      end else begin : g_lsb
         assign sh_d       = {din, sh_q[SH_W-1:BYTE_W]};
         assign start_addr = sh_q[ADDR_W-1:0];
         assign end_addr   = sh_q[SH_W-1:ADDR_W];
         assign nxt_start  = sh_d[ADDR_W-1:0];
         assign nxt_end    = sh_d[SH_W-1:ADDR_W];
      end
   endgenerate

   assign accept    = take && (left_q != '0);
   assign last_byte = accept && (left_q == CNT_W'(1));
   assign order_bad = nxt_end < nxt_start;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '0;
         left_q <= '0;
      end else if (arm) begin
         left_q <= CNT_W'(TOTAL);
      end else if (accept) begin
         sh_q   <= sh_d;
         left_q <= left_q - CNT_W'(1);
      end
   end

   // R4: once the count has run out, further bytes leave the addresses alone
   assert_no_extra_bytes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (left_q == '0 && !arm) |=> $stable(start_addr) && $stable(end_addr));
endmodule

// File: rtl/seq_addr_counter.sv
module seq_addr_counter #(
   parameter int ADDR_W    = 24,
   parameter int BURST_LEN = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [ADDR_W-1:0] end_addr,
   input  logic              begin_xfer,
   input  logic              issue,
   input  logic              burst_done,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              busy,
   output logic              finish
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BURST_LEN);

   logic [ADDR_W-1:0] cur_q;
   logic              busy_q;
   logic              last;

   generate
      if (BURST_LEN < 1 || (BURST_LEN & (BURST_LEN - 1)) != 0) begin : g_bad_burst
         $error("seq_addr_counter: BURST_LEN must be a power of two");
      end
   endgenerate

   assign last     = (end_addr - cur_q) < STEP;
   assign finish   = busy_q && burst_done && last;
   assign cur_addr = cur_q;
   assign busy     = busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q  <= '0;
         busy_q <= 1'b0;
      end else if (begin_xfer) begin
         cur_q  <= start_addr;
         busy_q <= 1'b0;
      end else if (busy_q) begin
         if (burst_done) begin
            busy_q <= 1'b0;
            if (!last) cur_q <= cur_q + STEP;
         end
      end else if (issue) begin
         busy_q <= 1'b1;
      end
   end

   // R7: an outstanding burst keeps its address until the controller ends it
   assert_burst_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !burst_done) |=> busy_q && $stable(cur_q));

   // R10: an end pulse with nothing outstanding moves nothing
   assert_stray_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && burst_done && !begin_xfer) |=> $stable(cur_q));
endmodule

// File: rtl/stream_cmd_sequencer.sv
module stream_cmd_sequencer
   import seq_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int BYTE_W    = 8,
   parameter int BURST_LEN = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_stb,
   input  logic              cmd_flag,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic              refresh_req,
   input  logic              burst_done,
   output logic              burst_req,
   output logic              burst_write,
   output logic              refresh_ack,
   output logic [ADDR_W-1:0] burst_addr,
   output logic [2:0]        status
);
   seq_state_e        state_q, state_d;
   seq_op_e           op;
   logic              cmd_stb, data_stb, at_rest, in_xfer;
   logic              arm, go, take, issue;
   logic              last_byte, order_bad, busy, finish;
   logic [ADDR_W-1:0] start_addr, end_addr;

   generate
      if (ADDR_W < BYTE_W) begin : g_bad_addr
         $error("stream_cmd_sequencer: ADDR_W must be at least BYTE_W");
      end
   endgenerate

   seq_cmd_decode #(.BYTE_W(BYTE_W)) i_decode (
      .code (byte_in),
      .op   (op)
   );

   seq_addr_loader #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .MSB_FIRST(MSB_FIRST)) i_loader (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm        (arm),
      .take       (take),
      .din        (byte_in),
      .start_addr (start_addr),
      .end_addr   (end_addr),
      .last_byte  (last_byte),
      .order_bad  (order_bad)
   );

   seq_addr_counter #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN)) i_counter (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_addr (start_addr),
      .end_addr   (end_addr),
      .begin_xfer (go),
      .issue      (issue),
      .burst_done (burst_done),
      .cur_addr   (burst_addr),
      .busy       (busy),
      .finish     (finish)
   );

   assign cmd_stb  = byte_stb && cmd_flag;
   assign data_stb = byte_stb && !cmd_flag;
   assign at_rest  = (state_q == ST_IDLE) || (state_q == ST_ERROR);
   assign in_xfer  = (state_q == ST_WRITE) || (state_q == ST_READ);
   assign arm      = at_rest && cmd_stb && (op == OP_SETUP);
   assign go       = at_rest && cmd_stb && (op == OP_WRITE || op == OP_READ)
                     && (end_addr >= start_addr);
   assign take     = (state_q == ST_LOAD) && data_stb;
   assign issue    = in_xfer && !busy && !refresh_req;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE, ST_ERROR: begin
            if (cmd_stb) begin
               case (op)
                  OP_SETUP: state_d = ST_LOAD;
                  OP_WRITE: state_d = go ? ST_WRITE : ST_ERROR;
                  OP_READ:  state_d = go ? ST_READ  : ST_ERROR;
                  default:  state_d = state_q;
               endcase
            end
         end
         ST_LOAD: begin
            if (last_byte) state_d = order_bad ? ST_ERROR : ST_IDLE;
         end
         ST_WRITE, ST_READ: begin
            if (finish) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign burst_req   = busy;
   assign burst_write = (state_q == ST_WRITE);
   assign refresh_ack = refresh_req && !busy;
   assign status      = state_q;

   // R9: a refresh grant never overlaps an outstanding burst
   assert_ack_between_R9: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_ack |-> !burst_req);

   // R9: a held request keeps new bursts from starting
   assert_no_start_on_refresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (refresh_req && !burst_req) |=> !burst_req);

   // R8: the current address stays within the programmed end
   assert_addr_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_xfer |-> burst_addr <= end_addr);

   // R2: a transfer state is left only through a completed burst
   assert_ignore_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_xfer && !(burst_req && burst_done)) |=> status == $past(status));

   // R4: loading is left only on a data byte
   assert_load_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LOAD && !data_stb) |=> state_q == ST_LOAD);

   // R5: the error state never has a burst outstanding
   assert_err_no_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ERROR) |-> !burst_req);
endmodule

// File: tb/test_stream_cmd_sequencer.sv
module test_stream_cmd_sequencer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stb = 1'b0, flag = 1'b0, rreq = 1'b0, done = 1'b0;
   logic [7:0]  din = '0;
   logic        breq, bwr, rack;
   logic [23:0] baddr;
   logic [2:0]  status;
   int          checks = 0;
   int          errors = 0;

   always #2 clk = ~clk;

   stream_cmd_sequencer i_stream_cmd_sequencer (
      .clk(clk), .rst_n(rst_n), .byte_stb(stb), .cmd_flag(flag), .byte_in(din),
      .refresh_req(rreq), .burst_done(done), .burst_req(breq), .burst_write(bwr),
      .refresh_ack(rack), .burst_addr(baddr), .status(status)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_byte(input logic f, input logic [7:0] v);
      stb = 1'b1; flag = f; din = v;
      @(negedge clk);
      stb = 1'b0; flag = 1'b0;
   endtask

   task automatic pulse_done();
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
   endtask

   task automatic wait_breq();
      for (int k = 0; k < 50 && !breq; k++) @(negedge clk);
      chk("R7 burst request seen", breq, 1);
   endtask

   task automatic setup(input logic [23:0] s, input logic [23:0] e, input logic [2:0] exp_st);
      send_byte(1'b1, 8'h01);
      chk("R4 loading after setup", status, 1);
      for (int i = 0; i < 6; i++) begin
         logic [7:0] b;
         b = (i < 3) ? 8'(s >> (8 * (2 - i))) : 8'(e >> (8 * (5 - i)));
         if (i == 2) begin
            send_byte(1'b1, 8'h02);
            chk("R2 flagged byte ignored while loading", status, 1);
         end
         send_byte(1'b0, b);
         if (i < 5) chk("R4 still loading", status, 1);
      end
      chk("R4/R5 status after six bytes", status, {29'd0, exp_st});
   endtask

   task automatic run_bursts(input logic [23:0] s, input logic [23:0] e, input logic wr);
      int n;
      n = int'((e - s) / 24'd8) + 1;
      for (int i = 0; i < n; i++) begin
         wait_breq();
         chk("R6/R7 burst address", baddr, 32'(s + 24'(8 * i)));
         chk("R6 burst direction", bwr, {31'd0, wr});
         chk("R8 address within end", (baddr <= e), 1);
         repeat (2) @(negedge clk);
         chk("R7 request held", breq, 1);
         chk("R7 address held", baddr, 32'(s + 24'(8 * i)));
         pulse_done();
      end
      chk("R8 idle after last burst", status, 0);
      chk("R8 no request after last burst", breq, 0);
   endtask

   task automatic t_reset();
      chk("R1 reset status", status, 0);
      chk("R1 reset request", breq, 0);
      chk("R1 reset address", baddr, 0);
   endtask

   task automatic t_basic_write();
      setup(24'h000010, 24'h000025, 3'd0);
      send_byte(1'b1, 8'h02);
      chk("R6 writing status", status, 2);
      run_bursts(24'h000010, 24'h000025, 1'b1);
   endtask

   task automatic t_read_single();
      setup(24'hABCDEF, 24'hABCDEF, 3'd0);
      send_byte(1'b1, 8'h03);
      chk("R6 reading status", status, 3);
      run_bursts(24'hABCDEF, 24'hABCDEF, 1'b0);
   endtask

   task automatic t_top_edge();
      setup(24'hFFFFF0, 24'hFFFFFF, 3'd0);
      send_byte(1'b1, 8'h02);
      run_bursts(24'hFFFFF0, 24'hFFFFFF, 1'b1);
   endtask

   task automatic t_ignored_idle();
      send_byte(1'b0, 8'h55);
      chk("R3 unflagged byte in idle", status, 0);
      send_byte(1'b1, 8'h07);
      chk("R3 unknown code", status, 0);
      send_byte(1'b1, 8'h00);
      chk("R3 no operation code", status, 0);
      send_byte(1'b0, 8'h01);
      chk("R3 unflagged setup value", status, 0);
      send_byte(1'b1, 8'h03);
      chk("R3 read after ignored bytes", status, 3);
      run_bursts(24'hFFFFF0, 24'hFFFFFF, 1'b0);
   endtask

   task automatic t_cmd_in_xfer();
      setup(24'h000100, 24'h00010F, 3'd0);
      send_byte(1'b1, 8'h02);
      wait_breq();
      send_byte(1'b1, 8'h01);
      chk("R2 setup ignored in transfer", status, 2);
      send_byte(1'b1, 8'h03);
      chk("R2 read ignored in transfer", status, 2);
      send_byte(1'b0, 8'hAA);
      chk("R2 address unchanged", baddr, 32'h100);
      pulse_done();
      wait_breq();
      chk("R7 second burst address", baddr, 32'h108);
      pulse_done();
      chk("R8 transfer ends", status, 0);
   endtask

   task automatic t_error();
      setup(24'h000200, 24'h0001FF, 3'd4);
      send_byte(1'b1, 8'h02);
      chk("R5 write in error", status, 4);
      repeat (5) @(negedge clk);
      chk("R5 no burst in error", breq, 0);
      send_byte(1'b1, 8'h03);
      chk("R5 read in error", status, 4);
      chk("R5 no burst after read", breq, 0);
      setup(24'h000300, 24'h000307, 3'd0);
      send_byte(1'b1, 8'h02);
      run_bursts(24'h000300, 24'h000307, 1'b1);
   endtask

   task automatic t_refresh();
      rreq = 1'b1;
      @(negedge clk);
      chk("R9 grant in idle", rack, 1);
      rreq = 1'b0;
      setup(24'h000040, 24'h00005F, 3'd0);
      send_byte(1'b1, 8'h02);
      wait_breq();
      chk("R9 first burst address", baddr, 32'h40);
      rreq = 1'b1;
      @(negedge clk);
      chk("R9 no grant mid burst", rack, 0);
      chk("R9 burst continues", breq, 1);
      pulse_done();
      chk("R9 grant after burst", rack, 1);
      chk("R9 no burst at grant", breq, 0);
      chk("R7 advanced by 8", baddr, 32'h48);
      repeat (3) @(negedge clk);
      chk("R9 held request blocks burst", breq, 0);
      pulse_done();
      chk("R10 stray done address", baddr, 32'h48);
      chk("R10 stray done status", status, 2);
      rreq = 1'b0;
      for (int i = 0; i < 3; i++) begin
         wait_breq();
         chk("R7 burst after refresh", baddr, 32'(24'h48 + 24'(8 * i)));
         pulse_done();
      end
      chk("R8 idle after refresh transfer", status, 0);
   endtask

   task automatic t_stray_idle();
      pulse_done();
      chk("R10 stray done idle status", status, 0);
      chk("R10 stray done idle address", baddr, 32'h58);
      chk("R10 stray done no request", breq, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic_write();
      t_read_single();
      t_top_edge();
      t_ignored_idle();
      t_cmd_in_xfer();
      t_error();
      t_refresh();
      t_stray_idle();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule